// File: doc/BRIEF.md
# Two-Slot Elastic Pipeline Stage

This block is one stage of an elastic channel. A plain pipeline register is split into two storage slots, each with its own load enable, so the stage can act as a two-entry FIFO between an upstream producer and a downstream consumer. Both sides use a valid/ready handshake. A word moves across an interface only on a rising clock edge where valid and ready on that interface are both high.

Back-pressure rules: upstream may raise `in_valid` at any time. While `in_ready` is low, the stage ignores `in_valid` and `in_data`. Downstream can hold `out_ready` low for as long as it needs. During that time `out_valid` stays high and `out_data` does not change. `in_ready` and `out_valid` come only from stored state, so neither depends on the same-cycle value of the other side's handshake input. Stages can therefore be chained with no combinational path through the chain.

A control machine with four states, held in two flip-flops, tracks which slots hold data and which word is older. The control logic does not depend on the data width, which is a parameter.

Top module: `elastic_stage`

## Requirements
- R1: `in_ready` is high exactly when the stage holds fewer than two words.
- R2: `out_valid` is high exactly when the stage holds at least one word.
- R3: A word is accepted only on an edge where `in_valid` and `in_ready` are both high. When `in_ready` is low, `in_valid` and `in_data` have no effect on the stored words or on the outputs.
- R4: Words leave in the order they arrived. `out_data` always shows the oldest stored word.
- R5: While one word is held, an accept and a release on the same edge leave exactly one word stored, and that word is the new one.
- R6: While `out_valid` is high and `out_ready` is low, `out_data` stays constant and `out_valid` stays high.
- R7: While `rst` is high at a rising edge (synchronous, active high), the stage becomes empty: `out_valid` goes low and `in_ready` goes high. A word offered during that edge is dropped.
- R8: Capacity is two words. After two accepts with no release, `in_ready` is low until a release happens.
- R9: A release when no word is held (`out_ready` high, `out_valid` low) has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream offers a word |
| in_ready | output | 1 | Stage has a free slot |
| in_data | input | WIDTH | Upstream word |
| out_valid | output | 1 | Stage holds at least one word |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | WIDTH | Oldest stored word |

## Verification
An accept and a release can fall on the same edge, either when the stage holds one word in slot A or one word in slot B. The bench provokes both cases from a stimulus table. It checks that the count stays at one and that the next `out_data` is the newly accepted word. A follow-on stream phase uses patterned stalls on both sides, so both orderings recur. A queue model in the bench compares every released word and both handshake outputs against the expected occupancy.

// File: rtl/eb_pkg.sv
package eb_pkg;

  // Occupancy states; in the full state slot A always holds the older word
  typedef enum logic [1:0] {
    ST_EMPTY = 2'b00,
    ST_A     = 2'b01,
    ST_B     = 2'b10,
    ST_FULL  = 2'b11
  } eb_state_e;

  // Source for a slot load
  typedef enum logic {
    SRC_IN   = 1'b0,
    SRC_PEER = 1'b1
  } slot_src_e;

endpackage

// File: rtl/eb_slot.sv
module eb_slot #(
  parameter int WIDTH = 32
) (
  input  logic                clk,
  input  logic                load,
  input  eb_pkg::slot_src_e   src,
  input  logic [WIDTH-1:0]    in_word,
  input  logic [WIDTH-1:0]    peer_word,
  output logic [WIDTH-1:0]    q
);
  import eb_pkg::*;

  logic [WIDTH-1:0] d;

  always_comb d = (src == SRC_PEER) ? peer_word : in_word;

  // Datapath slot: no reset, valid tracking is in control
  always_ff @(posedge clk) begin
    if (load) q <= d;
  end

endmodule

// File: rtl/eb_ctrl.sv
module eb_ctrl (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic              load_a,
  output logic              load_b,
  output eb_pkg::slot_src_e src_a,
  output logic              out_from_b
);
  import eb_pkg::*;

  eb_state_e st_q, st_d;
  logic push, pop;

  always_comb begin
    in_ready   = (st_q != ST_FULL);
    out_valid  = (st_q != ST_EMPTY);
    out_from_b = (st_q == ST_B);
  end

  always_comb begin
    push = in_valid && in_ready;
    pop  = out_valid && out_ready;
  end

  always_comb begin
    st_d   = st_q;
    load_a = 1'b0;
    load_b = 1'b0;
    src_a  = SRC_IN;
    unique case (st_q)
      ST_EMPTY: begin
        if (push) begin
          load_a = 1'b1;
          st_d   = ST_A;
        end
      end
      ST_A: begin
        if (push && pop) begin
          load_a = 1'b1;
        end else if (push) begin
          load_b = 1'b1;
          st_d   = ST_FULL;
        end else if (pop) begin
          st_d   = ST_EMPTY;
        end
      end
      ST_B: begin
        if (push && pop) begin
          load_b = 1'b1;
        end else if (push) begin
          // Older word moves to A so that full always means A is older
          load_a = 1'b1;
          src_a  = SRC_PEER;
          load_b = 1'b1;
          st_d   = ST_FULL;
        end else if (pop) begin
          st_d   = ST_EMPTY;
        end
      end
      ST_FULL: begin
        if (pop) st_d = ST_B;
      end
      default: st_d = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_EMPTY;
    else     st_q <= st_d;
  end

  // R5: a same-edge accept and release with one word held keeps one word
  a_r5_pushpop_keeps_one: assert property (@(posedge clk) disable iff (rst)
    (push && pop && (st_q != ST_FULL)) |=> (out_valid && in_ready));

  // R8: a full stage with no release stays full
  a_r8_full_holds: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !out_ready) |=> !in_ready);

  // R9: a release on an empty stage leaves it empty unless a word is accepted
  a_r9_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !in_valid) |=> !out_valid);

endmodule

// File: rtl/elastic_stage.sv
module elastic_stage #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  import eb_pkg::*;

  logic             load_a, load_b, out_from_b;
  slot_src_e        src_a;
  logic [WIDTH-1:0] slot_a_q, slot_b_q;

  eb_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load_a    (load_a),
    .load_b    (load_b),
    .src_a     (src_a),
    .out_from_b(out_from_b)
  );

  eb_slot #(.WIDTH(WIDTH)) u_slot_a (
    .clk      (clk),
    .load     (load_a),
    .src      (src_a),
    .in_word  (in_data),
    .peer_word(slot_b_q),
    .q        (slot_a_q)
  );

  eb_slot #(.WIDTH(WIDTH)) u_slot_b (
    .clk      (clk),
    .load     (load_b),
    .src      (SRC_IN),
    .in_word  (in_data),
    .peer_word(slot_a_q),
    .q        (slot_b_q)
  );

  always_comb out_data = out_from_b ? slot_b_q : slot_a_q;

  // R6: a stalled output holds its word
  a_r6_stall_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R3: slots are written only on an accepted word
  a_r3_load_needs_accept: assert property (@(posedge clk) disable iff (rst)
    (load_a || load_b) |-> (in_valid && in_ready));

  // R1: a refused offer never loads a slot
  a_r1_no_load_when_full: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> !(load_a || load_b));

endmodule

// File: tb/elastic_stage_test.sv
module elastic_stage_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst, in_valid, in_ready, out_valid, out_ready;
  logic [W-1:0] in_data, out_data;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  elastic_stage #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  // {in_valid, in_data, out_ready, exp_valid, exp_ready, chk_data, exp_data}
  localparam logic [68:0] VEC [NV] = '{
    {1'b1, 32'hD1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},   // empty, accept D1
    {1'b1, 32'hD2, 1'b0, 1'b1, 1'b1, 1'b1, 32'hD1},  // accept D2, now full
    {1'b1, 32'hD3, 1'b0, 1'b1, 1'b0, 1'b1, 32'hD1},  // R3 refused D3
    {1'b0, 32'h0,  1'b1, 1'b1, 1'b0, 1'b1, 32'hD1},  // release D1
    {1'b1, 32'hD4, 1'b1, 1'b1, 1'b1, 1'b1, 32'hD2},  // R5 in slot B
    {1'b1, 32'hD5, 1'b0, 1'b1, 1'b1, 1'b1, 32'hD4},  // fill from slot B
    {1'b0, 32'h0,  1'b1, 1'b1, 1'b0, 1'b1, 32'hD4},  // R4 order
    {1'b0, 32'h0,  1'b1, 1'b1, 1'b1, 1'b1, 32'hD5},
    {1'b0, 32'h0,  1'b1, 1'b0, 1'b1, 1'b0, 32'h0},   // R9 empty release
    {1'b1, 32'hD6, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},
    {1'b1, 32'hD7, 1'b1, 1'b1, 1'b1, 1'b1, 32'hD6},  // R5 in slot A
    {1'b0, 32'h0,  1'b0, 1'b1, 1'b1, 1'b1, 32'hD7},  // R6 stall
    {1'b0, 32'h0,  1'b1, 1'b1, 1'b1, 1'b1, 32'hD7},
    {1'b0, 32'h0,  1'b0, 1'b0, 1'b1, 1'b0, 32'h0}
  };

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic iv, input logic [W-1:0] d, input logic ordy);
    @(negedge clk);
    in_valid = iv; in_data = d; out_ready = ordy;
    #1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] model [64];
    int wr, rd;
    rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    // R7 reset state
    check(out_valid == 1'b0, "R7 valid after reset", W'(out_valid), 0);
    check(in_ready == 1'b1, "R7 ready after reset", W'(in_ready), 1);
    @(negedge clk); rst = 1'b0;

    // Table walk (R1 R2 R3 R4 R5 R6 R8 R9)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][68], VEC[i][67:36], VEC[i][35]);
      check(out_valid == VEC[i][34], "R2 out_valid", W'(out_valid), W'(VEC[i][34]));
      check(in_ready == VEC[i][33], "R1/R8 in_ready", W'(in_ready), W'(VEC[i][33]));
      if (VEC[i][32])
        check(out_data == VEC[i][31:0], "R4/R6 out_data", out_data, VEC[i][31:0]);
    end

    // R7: reset while full, with an offer on the reset edge
    drive(1'b1, 32'hE1, 1'b0);
    drive(1'b1, 32'hE2, 1'b0);
    drive(1'b0, 32'h0, 1'b0);
    check(in_ready == 1'b0, "R8 full before reset", W'(in_ready), 0);
    @(negedge clk); rst = 1'b1; in_valid = 1'b1; in_data = 32'hE3;
    @(negedge clk); rst = 1'b0; in_valid = 1'b0; #1;
    check(out_valid == 1'b0, "R7 valid cleared", W'(out_valid), 0);
    check(in_ready == 1'b1, "R7 ready restored", W'(in_ready), 1);

    // Stream with patterned stalls against a queue model (R1 R2 R4 R5)
    wr = 0; rd = 0;
    for (int c = 0; c < 60; c++) begin
      drive((c % 3) != 0, 32'hA000 + W'(c), (c % 5) != 1);
      check(in_ready == ((wr - rd) < 2), "R1 stream in_ready", W'(in_ready),
            W'((wr - rd) < 2));
      check(out_valid == ((wr - rd) > 0), "R2 stream out_valid", W'(out_valid),
            W'((wr - rd) > 0));
      if (out_valid && out_ready) begin
        check(out_data == model[rd % 64], "R4 stream order", out_data, model[rd % 64]);
        rd++;
      end
      if (in_valid && in_ready) begin
        model[wr % 64] = in_data;
        wr++;
      end
    end
    check(wr > 30, "R5 stream throughput", W'(wr), 31);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule